// File: doc/BRIEF.md
# MSI Capture Ring-Buffer Logger

The block takes message-signalled interrupt writes from the fabric and turns each one into a 16-byte record in a circular buffer in system memory. It then raises one level-sensitive interrupt toward the processor. Software places the buffer by writing a 64-bit base address in two halves. It picks one of four ring sizes, consumes records by moving a read offset, and learns where hardware has written up to from a write offset that hardware maintains.

A small two-entry input buffer absorbs interrupts that arrive while the memory write port is stalled. Back-pressure is raised when that buffer is full. Offsets are kept raw and masked to the ring size wherever they are used. When the ring fills, the block either drops new records and flags the overflow, or carries on and overwrites the oldest entry.

Top module: `msi_ring_logger`

## Requirements
- R1: After reset every register reads zero, and `irqOut`, `memReq` and `msiBusy` are low.
- R2: The register port decodes control at address 0, base high at 3, base low at 4, read offset at 5 and write offset at 6. Any other address reads zero. Bits 3:0 of both offsets always read zero.
- R3: Each stored record causes one write request at address {base high, base low} + (write offset masked to the ring). The data has the 16-bit vector in bits 15:0 (byte lane i is bits 8i+7:8i, lowest address first), bits 127:16 are zero and all 16 byte enables are set. Address and data stay stable until `memReady`.
- R4: The write offset grows by 16 in the edge where `memReq` and `memReady` are both high, and never wraps by itself. The raw value reads back unmasked.
- R5: Control bits 9:8 hold a value s that selects a ring of 2^(15+s) bytes. The offset mask is (ring size - 1) with bits 3:0 cleared.
- R6: `irqOut` is a registered level equal to enable (bit 0) AND interrupt enable (bit 3) AND (masked read offset != masked write offset). It falls one cycle after the write that empties the ring.
- R7: With full handling (bit 1) and stop-on-full (bit 4) set, an interrupt that arrives on a full ring is dropped and no write is issued. The ring is full when (masked write offset + 16) masked equals the masked read offset. The drop sets the sticky overflow flag in control bit 16, which clears only when software writes 1 to bit 16.
- R8: Without stop-on-full, an interrupt that arrives on a full ring is still written and the write offset still advances, overwriting the oldest record.
- R9: While enable is 0, incoming interrupts are ignored: nothing is buffered and no new write request starts. They are not recovered when enable returns.
- R10: Up to two interrupts are held while memory stalls. `msiBusy` is high while two are held, and an interrupt presented while `msiBusy` is high is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 3 | Register address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| msiValid | input | 1 | Incoming interrupt message present |
| msiVector | input | 16 | Interrupt number carried by the message |
| msiBusy | output | 1 | Input buffer full; messages are refused |
| memReq | output | 1 | Memory write request |
| memAddr | output | 64 | Memory write byte address |
| memData | output | 128 | Record data, little-endian lanes |
| memBe | output | 16 | Byte enables |
| memReady | input | 1 | Memory accepts the request this cycle |
| irqOut | output | 1 | Level interrupt to the processor |

## Verification
The assertions assume that software leaves the base and offset registers alone while a write request is outstanding. They also assume that `memReady` carries meaning only while `memReq` is high. The bench changes registers only between records, once the memory log shows the previous write has landed. It drives `memReady` from a model that raises it only against a live request, with a programmable wait or an indefinite hold. Ring-size sweeps preload the write offset just below the ring end, so the wrap is reached in a few records rather than thousands.

// File: rtl/msiring_pkg.sv
package msiring_pkg;
  typedef struct packed {
    logic pop;      // retire the head of the input buffer
    logic advance;  // step the write offset by one record
    logic drop;     // record discarded because the ring is full
  } strobe_t;

  typedef enum logic [0:0] {ST_IDLE, ST_WRITE} state_t;
endpackage

// File: rtl/msiring_ctrl.sv
module msiring_ctrl
  import msiring_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    enable,
  input  logic    fullEn,
  input  logic    stopOnFull,
  input  logic    fifoValid,
  input  logic    ringFull,
  input  logic    memReady,
  output logic    memReq,
  output strobe_t stb
);
  state_t state, stateNext;

  always_comb begin
    stb       = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (enable && fifoValid) begin
          if (fullEn && ringFull && stopOnFull) begin
            stb.drop = 1'b1;
            stb.pop  = 1'b1;
          end else begin
            stateNext = ST_WRITE;
          end
        end
      end
      ST_WRITE: begin
        if (memReady) begin
          stb.pop     = 1'b1;
          stb.advance = 1'b1;
          stateNext   = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign memReq = (state == ST_WRITE);

  AST_IDLE_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    (!memReq && !enable) |=> !memReq); // R9
  AST_DROP_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    stb.drop |=> !memReq); // R7
endmodule

// File: rtl/msiring_datapath.sv
module msiring_datapath
  import msiring_pkg::*;
#(
  parameter int REG_W      = 32,
  parameter int RA_W       = 3,
  parameter int VEC_W      = 16,
  parameter int MEM_W      = 128,
  parameter int ADDR_W     = 64,
  parameter int FIFO_DEPTH = 2,
  parameter int MIN_LOG    = 15
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [RA_W-1:0]      regAddr,
  input  logic                 regWrEn,
  input  logic [REG_W-1:0]     regWrData,
  output logic [REG_W-1:0]     regRdData,
  input  logic                 msiValid,
  input  logic [VEC_W-1:0]     msiVector,
  output logic                 msiBusy,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [MEM_W-1:0]     memData,
  output logic [MEM_W/8-1:0]   memBe,
  input  logic                 memReq,
  input  logic                 memReady,
  output logic                 irqOut,
  input  strobe_t              stb,
  output logic                 fifoValid,
  output logic                 ringFull,
  output logic                 enable,
  output logic                 fullEn,
  output logic                 stopOnFull
);
  localparam int REC_BYTES = MEM_W / 8;
  localparam int PTR_W     = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1);
  localparam logic [RA_W-1:0] A_CTRL  = RA_W'(0);
  localparam logic [RA_W-1:0] A_BASEH = RA_W'(3);
  localparam logic [RA_W-1:0] A_BASEL = RA_W'(4);
  localparam logic [RA_W-1:0] A_RDOFS = RA_W'(5);
  localparam logic [RA_W-1:0] A_WROFS = RA_W'(6);
  localparam logic [REG_W-1:0] ALIGN  = ~REG_W'(REC_BYTES - 1);

  // ---------------- registers ----------------
  logic             irqEn, ovfQ;
  logic [1:0]       sizeSel;
  logic [REG_W-1:0] baseHi, baseLo, rdOfs, wrRaw;
  logic ctrlWr, wrOfsWr;
  logic [REG_W-1:0] unusedWrBits;

  assign ctrlWr  = regWrEn && (regAddr == A_CTRL);
  assign wrOfsWr = regWrEn && (regAddr == A_WROFS);
  assign unusedWrBits = regWrData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enable <= 1'b0; fullEn <= 1'b0; irqEn <= 1'b0; stopOnFull <= 1'b0;
      sizeSel <= '0; ovfQ <= 1'b0;
      baseHi <= '0; baseLo <= '0; rdOfs <= '0; wrRaw <= '0;
    end else begin
      if (ctrlWr) begin
        enable     <= regWrData[0];
        fullEn     <= regWrData[1];
        irqEn      <= regWrData[3];
        stopOnFull <= regWrData[4];
        sizeSel    <= regWrData[9:8];
      end
      if (stb.drop)                    ovfQ <= 1'b1;
      else if (ctrlWr && regWrData[16]) ovfQ <= 1'b0;
      if (regWrEn && regAddr == A_BASEH) baseHi <= regWrData;
      if (regWrEn && regAddr == A_BASEL) baseLo <= regWrData;
      if (regWrEn && regAddr == A_RDOFS) rdOfs  <= regWrData & ALIGN;
      if (wrOfsWr)          wrRaw <= regWrData & ALIGN;
      else if (stb.advance) wrRaw <= wrRaw + REG_W'(REC_BYTES);
    end
  end

  // ---------------- offset arithmetic ----------------
  logic [REG_W-1:0] ringBytes, ofsMask, mWr, mRd, mWrNext;
  logic             ringEmpty;
  assign ringBytes = REG_W'(1) << (MIN_LOG + int'(sizeSel));
  assign ofsMask   = (ringBytes - REG_W'(1)) & ALIGN;
  assign mWr       = wrRaw & ofsMask;
  assign mRd       = rdOfs & ofsMask;
  assign mWrNext   = (mWr + REG_W'(REC_BYTES)) & ofsMask;
  assign ringEmpty = (mRd == mWr);
  assign ringFull  = (mWrNext == mRd);

  always_ff @(posedge clk) begin
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= enable && irqEn && !ringEmpty;
  end

  // ---------------- input buffer ----------------
  logic [VEC_W-1:0] fifoMem [FIFO_DEPTH];
  logic [PTR_W-1:0] wPtr, rPtr;
  logic [CNT_W-1:0] fifoCnt;
  logic             push;

  function automatic logic [PTR_W-1:0] bumpPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(FIFO_DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign msiBusy   = (fifoCnt == CNT_W'(FIFO_DEPTH));
  assign fifoValid = (fifoCnt != '0);
  assign push      = msiValid && enable && !msiBusy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wPtr <= '0; rPtr <= '0; fifoCnt <= '0;
    end else begin
      if (push) wPtr <= bumpPtr(wPtr);
      if (stb.pop) rPtr <= bumpPtr(rPtr);
      case ({push, stb.pop})
        2'b10:   fifoCnt <= fifoCnt + CNT_W'(1);
        2'b01:   fifoCnt <= fifoCnt - CNT_W'(1);
        default: fifoCnt <= fifoCnt;
      endcase
    end
  end

  for (genvar i = 0; i < FIFO_DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && wPtr == PTR_W'(i)) fifoMem[i] <= msiVector;
    end
  end

  // ---------------- memory request fields ----------------
  assign memAddr = {baseHi, baseLo} + ADDR_W'(mWr);
  assign memData = {{(MEM_W - VEC_W){1'b0}}, fifoMem[rPtr]};
  assign memBe   = '1;

  // ---------------- register read ----------------
  always_comb begin
    case (regAddr)
      A_CTRL:  regRdData = {15'b0, ovfQ, 6'b0, sizeSel, 3'b0, stopOnFull,
                            irqEn, 1'b0, fullEn, enable};
      A_BASEH: regRdData = baseHi;
      A_BASEL: regRdData = baseLo;
      A_RDOFS: regRdData = rdOfs;
      A_WROFS: regRdData = wrRaw;
      default: regRdData = '0;
    endcase
  end

  AST_WR_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memReady && !wrOfsWr) |=> (wrRaw == $past(wrRaw) + REG_W'(REC_BYTES))); // R4
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!(memReq && memReady) && !wrOfsWr) |=> $stable(wrRaw)); // R4
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady && !regWrEn) |=> ($stable(memAddr) && $stable(memData))); // R3
  AST_NO_PUSH_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (msiBusy && !stb.pop) |=> msiBusy); // R10
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ovfQ && !(ctrlWr && regWrData[16])) |=> ovfQ); // R7
  AST_IRQ_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !irqOut); // R6
endmodule

// File: rtl/msi_ring_logger.sv
module msi_ring_logger
  import msiring_pkg::*;
#(
  parameter int REG_W      = 32,
  parameter int RA_W       = 3,
  parameter int VEC_W      = 16,
  parameter int MEM_W      = 128,
  parameter int ADDR_W     = 64,
  parameter int FIFO_DEPTH = 2,
  parameter int MIN_LOG    = 15
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic [RA_W-1:0]    regAddr,
  input  logic               regWrEn,
  input  logic [REG_W-1:0]   regWrData,
  output logic [REG_W-1:0]   regRdData,
  input  logic               msiValid,
  input  logic [VEC_W-1:0]   msiVector,
  output logic               msiBusy,
  output logic               memReq,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [MEM_W-1:0]   memData,
  output logic [MEM_W/8-1:0] memBe,
  input  logic               memReady,
  output logic               irqOut
);
  strobe_t stb;
  logic fifoValid, ringFull, enable, fullEn, stopOnFull;

  msiring_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .fullEn(fullEn),
    .stopOnFull(stopOnFull), .fifoValid(fifoValid), .ringFull(ringFull),
    .memReady(memReady), .memReq(memReq), .stb(stb)
  );

  msiring_datapath #(
    .REG_W(REG_W), .RA_W(RA_W), .VEC_W(VEC_W), .MEM_W(MEM_W),
    .ADDR_W(ADDR_W), .FIFO_DEPTH(FIFO_DEPTH), .MIN_LOG(MIN_LOG)
  ) u_dp (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .msiValid(msiValid),
    .msiVector(msiVector), .msiBusy(msiBusy), .memAddr(memAddr),
    .memData(memData), .memBe(memBe), .memReq(memReq), .memReady(memReady),
    .irqOut(irqOut), .stb(stb), .fifoValid(fifoValid), .ringFull(ringFull),
    .enable(enable), .fullEn(fullEn), .stopOnFull(stopOnFull)
  );
endmodule

// File: tb/msi_ring_logger_bench.sv
module msi_ring_logger_bench;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [2:0]   regAddr = '0;
  logic         regWrEn = 1'b0;
  logic [31:0]  regWrData = '0;
  logic [31:0]  regRdData;
  logic         msiValid = 1'b0;
  logic [15:0]  msiVector = '0;
  logic         msiBusy, memReq, memReady = 1'b0, irqOut;
  logic [63:0]  memAddr;
  logic [127:0] memData;
  logic [15:0]  memBe;

  msi_ring_logger u_msi_ring_logger (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .msiValid(msiValid),
    .msiVector(msiVector), .msiBusy(msiBusy), .memReq(memReq),
    .memAddr(memAddr), .memData(memData), .memBe(memBe),
    .memReady(memReady), .irqOut(irqOut)
  );

  always #10 clk = ~clk;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  // memory model and write log
  int readyDelay = 0, waitCnt = 0;
  bit hold = 0;
  logic [63:0]  logAddr [64];
  logic [127:0] logData [64];
  logic [15:0]  logBe   [64];
  int logCnt = 0;

  always @(negedge clk) begin
    if (memReq) begin
      if (!hold && waitCnt >= readyDelay) memReady = 1'b1;
      else begin memReady = 1'b0; waitCnt++; end
    end else begin
      memReady = 1'b0; waitCnt = 0;
    end
  end

  always @(posedge clk) begin
    if (memReq && memReady && logCnt < 64) begin
      logAddr[logCnt] = memAddr; logData[logCnt] = memData;
      logBe[logCnt] = memBe; logCnt++;
    end
  end

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); regAddr = a; #1 d = regRdData;
  endtask

  task automatic sendMsi(input logic [15:0] v);
    @(negedge clk); msiValid = 1'b1; msiVector = v;
    @(negedge clk); msiValid = 1'b0;
  endtask

  task automatic waitLog(input int n);
    for (int i = 0; i < 300 && logCnt < n; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  localparam logic [63:0] BASE = 64'h0000_0012_3400_0000;

  initial begin
    #(20 * 150000);
    if (!finished) begin
      nFails++; nChecks++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int base0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      regRead(3'(a), rd); check("R1 reg after reset", 128'(rd), 128'(0));
    end
    check("R1 irqOut", 128'(irqOut), 128'(0));
    check("R1 memReq", 128'(memReq), 128'(0));
    check("R1 msiBusy", 128'(msiBusy), 128'(0));

    // R2 register map
    regWrite(3'd3, BASE[63:32]); regWrite(3'd4, BASE[31:0]);
    regWrite(3'd5, 32'h0000_1237);
    regRead(3'd3, rd); check("R2 base high", 128'(rd), 128'(BASE[63:32]));
    regRead(3'd4, rd); check("R2 base low", 128'(rd), 128'(BASE[31:0]));
    regRead(3'd5, rd); check("R2 read offset aligned", 128'(rd), 128'(32'h1230));
    regWrite(3'd6, 32'h0000_004F);
    regRead(3'd6, rd); check("R2 write offset aligned", 128'(rd), 128'(32'h40));
    regRead(3'd1, rd); check("R2 unmapped 1", 128'(rd), 128'(0));
    regRead(3'd7, rd); check("R2 unmapped 7", 128'(rd), 128'(0));

    // R5/R3/R4 sweep over every ring size, wrapping at the end
    for (int s = 0; s < 4; s++) begin
      int size;
      size = 1 << (15 + s);
      readyDelay = s;
      regWrite(3'd0, 32'h9 | (32'(s) << 8));
      regRead(3'd0, rd); check("R5 control readback", 128'(rd), 128'(32'h9 | (32'(s) << 8)));
      regWrite(3'd6, 32'(size - 16)); regWrite(3'd5, 32'h0);
      for (int k = 0; k < 3; k++) begin
        logic [15:0] v;
        v = 16'hA000 + 16'(s * 16 + k * 3 + 1);
        base0 = logCnt;
        sendMsi(v);
        waitLog(base0 + 1);
        check("R3 one write per record", 128'(logCnt), 128'(base0 + 1));
        check("R5 R3 record address", 128'(logAddr[base0]),
              128'(BASE + 64'((size - 16 + 16 * k) % size)));
        check("R3 record data", logData[base0], 128'(v));
        check("R3 byte enables", 128'(logBe[base0]), 128'(16'hFFFF));
        regRead(3'd6, rd); check("R4 raw write offset", 128'(rd), 128'(size - 16 + 16 * (k + 1)));
      end
      // masked write offset is 0x20, read offset 0: not empty
      check("R6 irq while not empty", 128'(irqOut), 128'(1));
      regWrite(3'd5, 32'h20);
      check("R6 irq still high right after write", 128'(irqOut), 128'(1));
      @(negedge clk);
      check("R6 irq low one cycle later", 128'(irqOut), 128'(0));
    end
    readyDelay = 1;

    // R6 interrupt enable off
    regWrite(3'd0, 32'h1); regWrite(3'd6, 32'h0); regWrite(3'd5, 32'h0);
    base0 = logCnt; sendMsi(16'h0042); waitLog(base0 + 1);
    check("R6 record written without irq enable", 128'(logCnt), 128'(base0 + 1));
    check("R6 irq masked", 128'(irqOut), 128'(0));
    regWrite(3'd0, 32'h9); @(negedge clk);
    check("R6 irq after enable", 128'(irqOut), 128'(1));

    // R7 stop-on-full drop and sticky overflow
    regWrite(3'd0, 32'h1B); regWrite(3'd6, 32'hF0); regWrite(3'd5, 32'h100);
    base0 = logCnt; sendMsi(16'h0BAD); repeat (10) @(negedge clk);
    check("R7 no write when full", 128'(logCnt), 128'(base0));
    regRead(3'd6, rd); check("R7 write offset unchanged", 128'(rd), 128'(32'hF0));
    regRead(3'd0, rd); check("R7 overflow flag set", 128'(rd), 128'(32'h1001B));
    regWrite(3'd0, 32'h1B); regRead(3'd0, rd);
    check("R7 overflow kept without clear bit", 128'(rd), 128'(32'h1001B));
    regWrite(3'd0, 32'h1001B); regRead(3'd0, rd);
    check("R7 overflow cleared", 128'(rd), 128'(32'h1B));

    // R8 overwrite when stop-on-full is off
    regWrite(3'd0, 32'h0B);
    base0 = logCnt; sendMsi(16'h0C0D); waitLog(base0 + 1);
    check("R8 record written on full ring", 128'(logCnt), 128'(base0 + 1));
    check("R8 address", 128'(logAddr[base0]), 128'(BASE + 64'hF0));
    regRead(3'd6, rd); check("R8 write offset advanced", 128'(rd), 128'(32'h100));
    regRead(3'd0, rd); check("R8 no overflow flag", 128'(rd), 128'(32'h0B));
    @(negedge clk); check("R8 ring now reads empty", 128'(irqOut), 128'(0));

    // R9 disabled block ignores messages
    regWrite(3'd0, 32'h08); regWrite(3'd6, 32'h0); regWrite(3'd5, 32'h0);
    base0 = logCnt; sendMsi(16'h0D0D);
    check("R9 not buffered", 128'(msiBusy), 128'(0));
    repeat (10) @(negedge clk);
    check("R9 no write while disabled", 128'(logCnt), 128'(base0));
    regWrite(3'd0, 32'h09); repeat (10) @(negedge clk);
    check("R9 nothing replayed", 128'(logCnt), 128'(base0));
    regRead(3'd6, rd); check("R9 write offset unchanged", 128'(rd), 128'(0));

    // R10 two-deep buffer and back-pressure
    hold = 1; base0 = logCnt;
    check("R10 not busy when empty", 128'(msiBusy), 128'(0));
    sendMsi(16'h1111); sendMsi(16'h2222);
    check("R10 busy with two held", 128'(msiBusy), 128'(1));
    sendMsi(16'h3333);
    hold = 0;
    waitLog(base0 + 2); repeat (20) @(negedge clk);
    check("R10 two records written", 128'(logCnt), 128'(base0 + 2));
    check("R10 first record", logData[base0], 128'(16'h1111));
    check("R10 second record", logData[base0 + 1], 128'(16'h2222));
    check("R10 busy released", 128'(msiBusy), 128'(0));

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule